// File: doc/BRIEF.md
# Remote add-and-move instruction unit

This unit runs a single "remote add-and-move" instruction for a small microcoded timer engine. When started at a program address, it reads that entry from a single-port instruction memory. Each entry holds three 32-bit words: program, control and data. The unit decodes the program word and selects one of five ALU source registers. It adds that register to the immediate data word. The result goes into the data word of a second entry, the remote entry. In the same write, the low 29 bits of the instruction's control word replace the remote entry's control field. The unit then reports the next program address and the break flag, and pulses `done`.

Source registers A and B are 25 bits wide. They add only into the upper data field, and the 7-bit high-resolution (HR) field of the immediate is passed through unchanged. Registers R, S and T are 32 bits wide and add across the whole word, so a carry out of the HR field ripples into the data field. The instruction normally takes one execute cycle. It takes one more when the remote entry is the next instruction, so that a following fetch sees the updated entry. The unit writes to none of the ALU registers. It only reads them.

`start`, `done`, `next_addr` and `brk` are plain control pins. There is no stream traffic, so there is no back-pressure: the unit ignores `start` while busy, and the memory is assumed to answer every read one cycle after `mem_rd`.

Top module: `radd_unit`

## Requirements
- R1: The program word is decoded as follows: bits 8:0 give the remote address, bits 12:9 the opcode (4'b0011 for this instruction), bits 21:13 the next program address and bit 22 the break flag.
- R2: Control word bits 2:0 select the operand: 0 = A, 1 = B, 2 = R, 3 = S, 4 = T. Codes 5 to 7 give a zero operand, so the immediate data word is written unchanged.
- R3: With A or B selected, the written data word is {imm[31:7] + reg[24:0] mod 2^25, imm[6:0]}. No carry reaches or leaves the HR field.
- R4: With R, S or T selected, the written data word is imm + reg mod 2^32.
- R5: The write sets the remote entry's control bits 28:0 to the instruction's control bits 28:0. It leaves the remote control bits 31:29 and the remote program word untouched.
- R6: The unit issues the read with `mem_rd` and `mem_addr` = pc in the cycle after `start` is sampled, and the write during the following cycle. When the remote address differs from the next address, `done` is high in the cycle after the write.
- R7: When the remote address equals the next address, `done` comes one cycle later than in R6.
- R8: `next_addr` and `brk` take the decoded values and are valid when `done` is high. They hold until the next completion.
- R9: `done` is a one-cycle pulse per started instruction.
- R10: `start` is ignored while an instruction is in progress.
- R11: A program word whose opcode is not 4'b0011 produces no memory write. It still completes with the R6 timing and updates `next_addr` and `brk`.
- R12: A synchronous reset returns the unit to idle. While and after reset, `done`, `mem_rd`, `mem_wr`, `next_addr` and `brk` are low, and any instruction in progress writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an instruction at `pc` (sampled when idle) |
| pc | input | 9 | Address of the instruction entry |
| reg_a | input | 25 | ALU register A |
| reg_b | input | 25 | ALU register B |
| reg_r | input | 32 | ALU register R |
| reg_s | input | 32 | ALU register S |
| reg_t | input | 32 | ALU register T |
| mem_addr | output | 9 | Memory address for read or write |
| mem_rd | output | 1 | Read strobe; data is returned the next cycle |
| mem_rprog | input | 32 | Program word read back |
| mem_rctrl | input | 32 | Control word read back |
| mem_rdata | input | 32 | Data word read back |
| mem_wr | output | 1 | Write strobe for control bits 28:0 and the data word |
| mem_wctrl | output | 29 | Control field to write |
| mem_wdata | output | 32 | Data word to write |
| done | output | 1 | Completion pulse |
| next_addr | output | 9 | Next program address of the last completed instruction |
| brk | output | 1 | Break flag of the last completed instruction |

## Verification
The bench releases `start` on the falling edge right after the sampling edge. It then counts falling edges until `done` is seen. That count must be 3 for an ordinary instruction or an opcode mismatch, and 4 when the remote entry is the next entry. This pins the result to the exact cycle the requirements give. The remote entry's words, `next_addr` and `brk` are compared on that same edge, because the write landed one or two edges earlier. One edge later, the bench confirms that `done` has dropped and the outputs are held. The busy-start and reset cases instead wait several cycles and check that a sentinel entry kept its value.

// File: rtl/radd_pkg.sv
package radd_pkg;

  localparam logic [3:0] OPC_RADD = 4'b0011;

  typedef enum logic [2:0] {
    SEL_A = 3'd0,
    SEL_B = 3'd1,
    SEL_R = 3'd2,
    SEL_S = 3'd3,
    SEL_T = 3'd4
  } src_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_STALL,
    ST_DONE
  } seq_state_e;

  function automatic logic is_narrow(input logic [2:0] code);
    return (code == SEL_A) || (code == SEL_B);
  endfunction

  function automatic logic is_wide(input logic [2:0] code);
    return (code == SEL_R) || (code == SEL_S) || (code == SEL_T);
  endfunction

endpackage

// File: rtl/radd_decode.sv
module radd_decode
  import radd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int CTRL_W = 29,
  parameter int SEL_W  = 3
) (
  input  logic [31:0]       prog_word,
  input  logic [31:0]       ctrl_word,
  output logic [ADDR_W-1:0] remote_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic              brk_flag,
  output logic              opc_match,
  output logic [SEL_W-1:0]  sel_code,
  output logic [CTRL_W-1:0] imm_ctrl
);
  localparam int OPC_LO  = ADDR_W;
  localparam int OPC_HI  = ADDR_W + 3;
  localparam int NEXT_LO = ADDR_W + 4;
  localparam int NEXT_HI = 2 * ADDR_W + 3;
  localparam int BRK_BIT = 2 * ADDR_W + 4;

  always_comb begin
    remote_addr = prog_word[ADDR_W-1:0];
    next_addr   = prog_word[NEXT_HI:NEXT_LO];
    brk_flag    = prog_word[BRK_BIT];
    opc_match   = (prog_word[OPC_HI:OPC_LO] == OPC_RADD);
    sel_code    = ctrl_word[SEL_W-1:0];
    imm_ctrl    = ctrl_word[CTRL_W-1:0];
  end

endmodule

// File: rtl/radd_adder.sv
module radd_adder
  import radd_pkg::*;
#(
  parameter int DATA_W = 25,
  parameter int HR_W   = 7,
  localparam int WORD_W = DATA_W + HR_W
) (
  input  logic [2:0]        sel_code,
  input  logic [WORD_W-1:0] imm_word,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [WORD_W-1:0] reg_r,
  input  logic [WORD_W-1:0] reg_s,
  input  logic [WORD_W-1:0] reg_t,
  output logic [WORD_W-1:0] sum_word
);
  logic [DATA_W-1:0] narrow_op;
  logic [WORD_W-1:0] wide_op;
  logic [DATA_W-1:0] narrow_sum;
  logic [WORD_W-1:0] wide_sum;

  always_comb begin
    narrow_op = '0;
    wide_op   = '0;
    unique case (sel_code)
      SEL_A:   narrow_op = reg_a;
      SEL_B:   narrow_op = reg_b;
      SEL_R:   wide_op   = reg_r;
      SEL_S:   wide_op   = reg_s;
      SEL_T:   wide_op   = reg_t;
      default: wide_op   = '0;
    endcase
  end

  always_comb begin
    narrow_sum = imm_word[WORD_W-1:HR_W] + narrow_op;
    wide_sum   = imm_word + wide_op;
    if (is_narrow(sel_code)) sum_word = {narrow_sum, imm_word[HR_W-1:0]};
    else                     sum_word = wide_sum;
  end

endmodule

// File: rtl/radd_seq.sv
module radd_seq
  import radd_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc,
  input  logic              opc_match,
  input  logic [ADDR_W-1:0] remote_addr,
  input  logic [ADDR_W-1:0] next_dec,
  input  logic              brk_dec,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic [ADDR_W-1:0] next_addr,
  output logic              brk
);
  seq_state_e        state;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] next_q;
  logic              brk_q;
  logic              hazard;

  assign hazard = opc_match && (remote_addr == next_dec);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pc_q   <= '0;
      next_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          pc_q  <= pc;
          state <= ST_FETCH;
        end
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          next_q <= next_dec;
          brk_q  <= brk_dec;
          state  <= hazard ? ST_STALL : ST_DONE;
        end
        ST_STALL: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd    = (state == ST_FETCH);
    mem_wr    = (state == ST_EXEC) && opc_match;
    mem_addr  = (state == ST_FETCH) ? pc_q : remote_addr;
    done      = (state == ST_DONE);
    next_addr = next_q;
    brk       = brk_q;
  end

  AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_PLAIN_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && !hazard) |=> done); // R6
  AST_HAZARD_STALL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && hazard) |=> !done ##1 done); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (start && state != ST_IDLE) |=> state != ST_FETCH); // R10
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !mem_rd); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_EXEC) |=> $stable(next_addr) && $stable(brk)); // R8

endmodule

// File: rtl/radd_unit.sv
module radd_unit
  import radd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 25,
  parameter int HR_W   = 7,
  parameter int CTRL_W = 29,
  localparam int WORD_W = DATA_W + HR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [WORD_W-1:0] reg_r,
  input  logic [WORD_W-1:0] reg_s,
  input  logic [WORD_W-1:0] reg_t,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [31:0]       mem_rprog,
  input  logic [31:0]       mem_rctrl,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_wr,
  output logic [CTRL_W-1:0] mem_wctrl,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic [ADDR_W-1:0] next_addr,
  output logic              brk
);
  logic [ADDR_W-1:0] remote_addr;
  logic [ADDR_W-1:0] next_dec;
  logic              brk_dec;
  logic              opc_match;
  logic [2:0]        sel_code;

  radd_decode #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .SEL_W(3)) i_decode (
    .prog_word  (mem_rprog),
    .ctrl_word  (mem_rctrl),
    .remote_addr(remote_addr),
    .next_addr  (next_dec),
    .brk_flag   (brk_dec),
    .opc_match  (opc_match),
    .sel_code   (sel_code),
    .imm_ctrl   (mem_wctrl)
  );

  radd_adder #(.DATA_W(DATA_W), .HR_W(HR_W)) i_adder (
    .sel_code(sel_code),
    .imm_word(mem_rdata),
    .reg_a   (reg_a),
    .reg_b   (reg_b),
    .reg_r   (reg_r),
    .reg_s   (reg_s),
    .reg_t   (reg_t),
    .sum_word(mem_wdata)
  );

  radd_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pc         (pc),
    .opc_match  (opc_match),
    .remote_addr(remote_addr),
    .next_dec   (next_dec),
    .brk_dec    (brk_dec),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .done       (done),
    .next_addr  (next_addr),
    .brk        (brk)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !done && !mem_wr && !mem_rd && next_addr == '0 && !brk); // R12
  AST_HR_PASS: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && is_narrow(sel_code)) |-> mem_wdata[HR_W-1:0] == mem_rdata[HR_W-1:0]); // R3
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !is_narrow(sel_code) && !is_wide(sel_code)) |-> mem_wdata == mem_rdata); // R2

endmodule

// File: tb/test_radd_unit.sv
module test_radd_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [8:0]  pc = '0;
  logic [24:0] reg_a = '0, reg_b = '0;
  logic [31:0] reg_r = '0, reg_s = '0, reg_t = '0;
  logic [8:0]  mem_addr;
  logic        mem_rd, mem_wr, done, brk;
  logic [31:0] mem_rprog, mem_rctrl, mem_rdata, mem_wdata;
  logic [28:0] mem_wctrl;
  logic [8:0]  next_addr;

  logic [31:0] prog_m [512];
  logic [31:0] ctrl_m [512];
  logic [31:0] data_m [512];
  logic        tb_we = 1'b0;
  logic [8:0]  tb_addr = '0;
  logic [31:0] tb_prog = '0, tb_ctrl = '0, tb_data = '0;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  radd_unit i_radd_unit (
    .clk(clk), .rst(rst), .start(start), .pc(pc),
    .reg_a(reg_a), .reg_b(reg_b), .reg_r(reg_r), .reg_s(reg_s), .reg_t(reg_t),
    .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rprog(mem_rprog), .mem_rctrl(mem_rctrl), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wctrl(mem_wctrl), .mem_wdata(mem_wdata),
    .done(done), .next_addr(next_addr), .brk(brk)
  );

  always @(posedge clk) begin
    if (tb_we) begin
      prog_m[tb_addr] <= tb_prog;
      ctrl_m[tb_addr] <= tb_ctrl;
      data_m[tb_addr] <= tb_data;
    end else if (mem_wr) begin
      ctrl_m[mem_addr][28:0] <= mem_wctrl;
      data_m[mem_addr]       <= mem_wdata;
    end
    if (mem_rd) begin
      mem_rprog <= prog_m[mem_addr];
      mem_rctrl <= ctrl_m[mem_addr];
      mem_rdata <= data_m[mem_addr];
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [8:0] a, input logic [31:0] p, input logic [31:0] c, input logic [31:0] d);
    tb_we = 1'b1; tb_addr = a; tb_prog = p; tb_ctrl = c; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [31:0] mix(input int x);
    logic [31:0] v;
    v = 32'(x) * 32'h9E3779B1;
    return v ^ (v >> 15) ^ 32'h5A5A_3C3C;
  endfunction

  function automatic logic [31:0] mkprog(input logic brkf, input logic [8:0] nxt,
                                         input logic [3:0] opc, input logic [8:0] rem);
    return {9'd0, brkf, nxt, opc, rem};
  endfunction

  // Starts at pc and returns the number of falling edges until done is seen.
  task automatic launch(input logic [8:0] a, output int n);
    pc = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    logic [31:0] imm, ctl, exp;
    logic [8:0] pa, ra, na;
    logic bf;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!done && !mem_rd && !mem_wr, "R12 reset strobes", {29'd0, done, mem_rd, mem_wr}, 32'd0);
    check(next_addr == 9'd0 && !brk, "R12 reset outputs", {22'd0, brk, next_addr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int idx = 0; idx < 64; idx++) begin
      int sel = idx % 8;
      int k = (idx / 8) % 4;
      logic hit = idx[5];
      pa = 9'(idx * 7 + 1);
      ra = 9'(idx * 7 + 3);
      na = hit ? ra : 9'(ra + 9'd1);
      bf = idx[0];
      if (k == 0) begin
        imm = 32'hFFFF_FFFF;
        reg_a = 25'd1; reg_b = 25'd1; reg_r = 32'd1; reg_s = 32'd1; reg_t = 32'd1;
      end else if (k == 1) begin
        imm = 32'h0000_007F;
        reg_a = 25'd1; reg_b = 25'd1; reg_r = 32'd1; reg_s = 32'd1; reg_t = 32'd1;
      end else begin
        imm = mix(idx);
        reg_a = mix(idx + 100)[24:0]; reg_b = mix(idx + 200)[24:0];
        reg_r = mix(idx + 300); reg_s = mix(idx + 400); reg_t = mix(idx + 500);
      end
      ctl = {mix(idx + 900)[31:3], 3'(sel)};
      case (sel)
        0: exp = {imm[31:7] + reg_a, imm[6:0]};
        1: exp = {imm[31:7] + reg_b, imm[6:0]};
        2: exp = imm + reg_r;
        3: exp = imm + reg_s;
        4: exp = imm + reg_t;
        default: exp = imm;
      endcase
      load(pa, mkprog(bf, na, 4'b0011, ra), ctl, imm);
      load(ra, 32'h1234_5678, {3'b101, 29'h0ABC_DEF}, 32'hDEAD_BEEF);
      launch(pa, n);
      check(n == (hit ? 4 : 3), hit ? "R7 stalled completion" : "R6 completion cycle",
            32'(n), hit ? 32'd4 : 32'd3);
      check(data_m[ra] == exp, sel < 2 ? "R3 narrow sum" : (sel < 5 ? "R4 wide sum" : "R2 zero operand"),
            data_m[ra], exp);
      check(ctrl_m[ra] == {3'b101, ctl[28:0]}, "R5 control field", ctrl_m[ra], {3'b101, ctl[28:0]});
      check(prog_m[ra] == 32'h1234_5678, "R5 program word kept", prog_m[ra], 32'h1234_5678);
      check(next_addr == na && brk == bf, "R1 next address and break", {22'd0, brk, next_addr}, {22'd0, bf, na});
      @(negedge clk);
      check(!done, "R9 done pulse width", {31'd0, done}, 32'd0);
      check(next_addr == na && brk == bf, "R8 outputs held", {22'd0, brk, next_addr}, {22'd0, bf, na});
    end

    // R10: second start while busy is ignored
    load(9'd500, mkprog(1'b0, 9'd11, 4'b0011, 9'd502), 32'd2, 32'd5);
    load(9'd502, 32'd0, 32'd0, 32'd0);
    load(9'd504, mkprog(1'b1, 9'd12, 4'b0011, 9'd506), 32'd2, 32'd9);
    load(9'd506, 32'd0, 32'd0, 32'h0BAD_F00D);
    reg_r = 32'd10;
    pc = 9'd500; start = 1'b1;
    @(negedge clk);
    pc = 9'd504;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    for (int c = 0; c < 8; c++) begin
      if (done) n++;
      @(negedge clk);
    end
    check(n == 1, "R10 single completion", 32'(n), 32'd1);
    check(data_m[9'd506] == 32'h0BAD_F00D, "R10 busy start ignored", data_m[9'd506], 32'h0BAD_F00D);
    check(data_m[9'd502] == 32'd15, "R10 first instruction done", data_m[9'd502], 32'd15);

    // R11: opcode mismatch writes nothing
    load(9'd510, mkprog(1'b1, 9'd77, 4'b0101, 9'd508), 32'd2, 32'd1);
    load(9'd508, 32'd0, 32'd3, 32'h7777_0000);
    launch(9'd510, n);
    check(n == 3, "R11 completion cycle", 32'(n), 32'd3);
    check(data_m[9'd508] == 32'h7777_0000 && ctrl_m[9'd508] == 32'd3, "R11 no write",
          data_m[9'd508], 32'h7777_0000);
    check(next_addr == 9'd77 && brk, "R11 next address", {22'd0, brk, next_addr}, {22'd0, 1'b1, 9'd77});

    // R12: reset during fetch cancels the write
    load(9'd490, mkprog(1'b0, 9'd5, 4'b0011, 9'd492), 32'd2, 32'd1);
    load(9'd492, 32'd0, 32'd0, 32'h4444_4444);
    pc = 9'd490; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    for (int c = 0; c < 5; c++) begin
      if (done) n++;
      @(negedge clk);
    end
    check(data_m[9'd492] == 32'h4444_4444, "R12 write cancelled", data_m[9'd492], 32'h4444_4444);
    check(n == 0 && next_addr == 9'd0, "R12 idle after reset", {23'd0, next_addr}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule